// File: doc/BRIEF.md
# DMA Word Burst Splitter

This block turns one sequential word transfer, such as a USB packet moved by a DMA channel, into a series of bus bursts on a request/grant master port. Software-side setup is not modelled. A single `start_i` pulse supplies the first word address, the channel byte length, the endpoint size in words and a lock option. The block then issues one burst after another. Each burst has a fixed start address and beat count that hold steady while the request is up. The block counts beats on a valid/ready handshake and signals completion with a one-cycle pulse.

Each burst is as long as the smallest of four limits: the endpoint size, the words still owed, the words left before the next 1 KB address boundary, and 256 beats. Endpoint sizes of 128 words give bulk-style bursts and 256 words give isochronous-style bursts. If the grant is withdrawn during a burst, the burst ends. The remaining words are requested again as a fresh burst that starts at the next unsent address. With lock enabled, the bus lock output covers every burst of the buffer and the gaps between them.

Top module: `dma_burst_splitter`

## Requirements
- R1: Beat addresses start at the word-aligned start address and rise by 4 per beat. A beat is taken only in a cycle where `beat_valid_o`, `bus_gnt_i` and `beat_ready_i` are all high, and `beat_addr_o` holds otherwise.
- R2: Every issued burst has between 1 and 256 beats inclusive.
- R3: No burst crosses a 1 KB address boundary. When the transfer reaches a boundary, the next burst starts exactly at that boundary address.
- R4: If `bus_gnt_i` is low in any cycle of an active burst, that burst ends. A new request follows whose `burst_addr_o` is the next untransferred word and whose beat count is sized from the words still owed.
- R5: The beat count is the minimum of the effective endpoint size, the remaining words (bytes/4) and the words to the next 1 KB boundary. An `ep_words_i` value of 0 or above 256 counts as 256.
- R6: With an endpoint size of 128, a 1024-byte aligned transfer takes two 128-beat bursts. With 256 it takes one 256-beat burst, and a 2048-byte transfer takes two.
- R7: `bus_lock_o` equals `busy_o` when `lock_en_i` was high at start, and stays 0 when it was low.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last beat is taken, and `remain_o` reads 0 then.
- R9: `burst_addr_o` and `burst_beats_o` do not change in any cycle where `bus_req_o` was already high in the previous cycle.
- R10: A nonzero `byte_len_i[1:0]` at start gives a one-cycle `err_o` in the next cycle, with no request, no done and `busy_o` low.
- R11: A zero byte length gives `done_o` in the cycle after start, and no bus request is ever raised.
- R12: During and right after reset, `bus_req_o`, `bus_lock_o`, `beat_valid_o`, `busy_o`, `done_o` and `err_o` are 0 and `remain_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| start_addr_i | input | ADDR_W | First byte address (low two bits ignored) |
| byte_len_i | input | LEN_W | Channel byte length |
| ep_words_i | input | $clog2(MAX_BEATS)+1 | Endpoint size in words |
| lock_en_i | input | 1 | Hold bus lock over the whole buffer |
| bus_req_o | output | 1 | Burst request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_lock_o | output | 1 | Bus lock |
| burst_addr_o | output | ADDR_W | Start address of the current burst |
| burst_beats_o | output | $clog2(MAX_BEATS)+1 | Beat count of the current burst |
| beat_valid_o | output | 1 | Data phase active |
| beat_ready_i | input | 1 | Slave accepts the beat |
| beat_addr_o | output | ADDR_W | Address of the current beat |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle bad-length pulse |
| remain_o | output | LEN_W | Bytes still to move |

## Verification
A corrupted address or remaining-byte counter appears on `beat_addr_o` at the very next accepted beat. It also shows as a burst count or burst size that differs from the min rule as soon as the next request rises. A wrong beat-left counter or state shows as a burst that ends early or late. That error is caught within one burst through the number of request edges, the total of taken beats and the timing of `done_o`. A lost lock or an unstable burst descriptor is visible in the same cycle it occurs.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PLAN,
    ST_REQ,
    ST_BURST
  } split_st_e;
endpackage

// File: rtl/burst_sizer.sv
module burst_sizer #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int MAX_BEATS   = 256,
  parameter int BOUND_BYTES = 1024
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [LEN_W-1:0]             remain_i,
  input  logic [$clog2(MAX_BEATS):0]   ep_words_i,
  output logic [$clog2(MAX_BEATS):0]   beats_o
);
  localparam int BEAT_W  = $clog2(MAX_BEATS) + 1;
  localparam int BOUND_W = $clog2(BOUND_BYTES);
  localparam int BWORDS  = BOUND_BYTES / 4;
  localparam int CMP_W   = LEN_W + BOUND_W;

  logic [CMP_W-1:0] ep_eff, to_bound, rem_words, pick;

  always_comb begin
    if (ep_words_i == '0 || ep_words_i > BEAT_W'(MAX_BEATS))
      ep_eff = CMP_W'(MAX_BEATS);
    else
      ep_eff = CMP_W'(ep_words_i);
    to_bound  = CMP_W'(BWORDS) - CMP_W'(addr_i[BOUND_W-1:2]);
    rem_words = CMP_W'(remain_i[LEN_W-1:2]);
    pick = ep_eff;
    if (to_bound < pick)  pick = to_bound;
    if (rem_words < pick) pick = rem_words;
    beats_o = BEAT_W'(pick);
  end

  always_comb begin
    assert_size_cap_R2: assert (beats_o <= BEAT_W'(MAX_BEATS));
  end
endmodule

// File: rtl/xfer_track.sv
module xfer_track #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  remain_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      remain_o <= '0;
    end else if (load_i) begin
      addr_o   <= {addr_i[ADDR_W-1:2], 2'b00};
      remain_o <= len_i;
    end else if (step_i) begin
      addr_o   <= addr_o + ADDR_W'(4);
      remain_o <= remain_o - LEN_W'(4);
    end
  end

  // remaining bytes never wrap below zero
  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |-> remain_o >= LEN_W'(4));
endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter
  import dma_split_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int MAX_BEATS   = 256,
  parameter int BOUND_BYTES = 1024
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [ADDR_W-1:0]           start_addr_i,
  input  logic [LEN_W-1:0]            byte_len_i,
  input  logic [$clog2(MAX_BEATS):0]  ep_words_i,
  input  logic                        lock_en_i,
  output logic                        bus_req_o,
  input  logic                        bus_gnt_i,
  output logic                        bus_lock_o,
  output logic [ADDR_W-1:0]           burst_addr_o,
  output logic [$clog2(MAX_BEATS):0]  burst_beats_o,
  output logic                        beat_valid_o,
  input  logic                        beat_ready_i,
  output logic [ADDR_W-1:0]           beat_addr_o,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        err_o,
  output logic [LEN_W-1:0]            remain_o
);
  localparam int BEAT_W  = $clog2(MAX_BEATS) + 1;
  localparam int BOUND_W = $clog2(BOUND_BYTES);
  localparam int BWORDS  = BOUND_BYTES / 4;

  split_st_e          st_q;
  logic [BEAT_W-1:0]  ep_q, left_q, size_w;
  logic               lock_q, done_q, err_q;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   cur_rem;

  logic start_ok, len_bad, len_zero, load, accept, last_beat, fin;

  assign start_ok  = (st_q == ST_IDLE) && start_i;
  assign len_bad   = byte_len_i[1:0] != 2'b00;
  assign len_zero  = byte_len_i == '0;
  assign load      = start_ok && !len_bad && !len_zero;
  assign accept    = (st_q == ST_BURST) && bus_gnt_i && beat_ready_i;
  assign last_beat = accept && (left_q == BEAT_W'(1));
  assign fin       = last_beat && (cur_rem == LEN_W'(4));

  xfer_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .addr_i   (start_addr_i),
    .len_i    (byte_len_i),
    .step_i   (accept),
    .addr_o   (cur_addr),
    .remain_o (cur_rem)
  );

  burst_sizer #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BEATS(MAX_BEATS), .BOUND_BYTES(BOUND_BYTES)
  ) u_sizer (
    .addr_i     (cur_addr),
    .remain_i   (cur_rem),
    .ep_words_i (ep_q),
    .beats_o    (size_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      ep_q          <= '0;
      lock_q        <= 1'b0;
      left_q        <= '0;
      burst_addr_o  <= '0;
      burst_beats_o <= '0;
      done_q        <= 1'b0;
      err_q         <= 1'b0;
    end else begin
      done_q <= (start_ok && len_zero) || fin;
      err_q  <= start_ok && len_bad;
      unique case (st_q)
        ST_IDLE: if (load) begin
          st_q   <= ST_PLAN;
          ep_q   <= ep_words_i;
          lock_q <= lock_en_i;
        end
        ST_PLAN: begin
          st_q          <= ST_REQ;
          burst_addr_o  <= cur_addr;
          burst_beats_o <= size_w;
          left_q        <= size_w;
        end
        ST_REQ: if (bus_gnt_i) st_q <= ST_BURST;
        ST_BURST: begin
          if (accept) begin
            left_q <= left_q - BEAT_W'(1);
            if (last_beat) st_q <= fin ? ST_IDLE : ST_PLAN;
          end else if (!bus_gnt_i) begin
            st_q <= ST_PLAN;  // grant lost: reissue from next word
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o    = (st_q == ST_REQ) || (st_q == ST_BURST);
  assign beat_valid_o = st_q == ST_BURST;
  assign beat_addr_o  = cur_addr;
  assign busy_o       = st_q != ST_IDLE;
  assign bus_lock_o   = lock_q && busy_o;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign remain_o     = cur_rem;

  assert_beats_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> burst_beats_o != '0 && burst_beats_o <= BEAT_W'(MAX_BEATS));

  assert_no_cross_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> ({1'b0, burst_addr_o[BOUND_W-1:2]} + BEAT_W'(burst_beats_o)) <= BEAT_W'(BWORDS));

  assert_ep_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (ep_q == '0 || ep_q > BEAT_W'(MAX_BEATS) || burst_beats_o <= ep_q));

  assert_desc_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && $past(bus_req_o) |-> $stable(burst_beats_o) && $stable(burst_addr_o));

  assert_addr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !(bus_gnt_i && beat_ready_i) |=> $stable(beat_addr_o));

  assert_done_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> remain_o == '0 && !busy_o);

  assert_err_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !bus_req_o && !done_o);
endmodule

// File: tb/tb_dma_burst_splitter.sv
module tb_dma_burst_splitter;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, lock_en_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [15:0] byte_len_i = '0;
  logic [8:0]  ep_words_i = '0;
  logic        bus_gnt_i = 1'b0, beat_ready_i = 1'b0;
  logic        bus_req_o, bus_lock_o, beat_valid_o, busy_o, done_o, err_o;
  logic [31:0] burst_addr_o, beat_addr_o;
  logic [8:0]  burst_beats_o;
  logic [15:0] remain_o;

  always #2 clk_i = ~clk_i;

  dma_burst_splitter dut (.*);

  int errors = 0, checks = 0, cyc = 0;
  int nb, first_beats, bseen, sec_beats;
  int viol_addr, viol_bound, viol_cap, viol_hold, viol_lock;
  logic [31:0] exp_addr, sec_addr, last_baddr;
  logic [8:0]  last_beats;
  logic        req_prev, lock_cfg, stall_en, drop_en, dropped;
  int          blk_cnt, ep_eff;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) cyc++;

  always @(negedge clk_i) begin
    if (bus_req_o && !req_prev) begin
      nb++;
      if (nb == 1) first_beats = burst_beats_o;
      if (nb == 2) begin sec_addr = burst_addr_o; sec_beats = burst_beats_o; end
      if ((burst_addr_o[9:2] + burst_beats_o) > 256) viol_bound++;
      if (burst_beats_o == 0 || burst_beats_o > 256 || burst_beats_o > ep_eff) viol_cap++;
    end
    if (bus_req_o && req_prev &&
        (burst_beats_o != last_beats || burst_addr_o != last_baddr)) viol_hold++;
    req_prev   = bus_req_o;
    last_beats = burst_beats_o;
    last_baddr = burst_addr_o;
    if (bus_lock_o !== (busy_o && lock_cfg)) viol_lock++;
    if (blk_cnt > 0) blk_cnt--;
    if (drop_en && !dropped && beat_valid_o && bseen == 5) begin blk_cnt = 3; dropped = 1; end
    bus_gnt_i    = bus_req_o && blk_cnt == 0;
    beat_ready_i = !(stall_en && (cyc % 3 == 0));
    if (beat_valid_o && bus_gnt_i && beat_ready_i) begin
      if (beat_addr_o != exp_addr) viol_addr++;
      exp_addr = exp_addr + 4;
      bseen++;
    end
  end

  task automatic launch(input logic [31:0] a, input logic [15:0] l, input logic [8:0] e,
                        input logic lk, input logic st, input logic dr);
    @(negedge clk_i);
    nb = 0; first_beats = 0; bseen = 0; sec_beats = 0; sec_addr = 0;
    viol_addr = 0; viol_bound = 0; viol_cap = 0; viol_hold = 0; viol_lock = 0;
    exp_addr = {a[31:2], 2'b00}; lock_cfg = lk; stall_en = st; drop_en = dr; dropped = 0;
    ep_eff = (e == 0 || e > 256) ? 256 : int'(e);
    start_addr_i = a; byte_len_i = l; ep_words_i = e; lock_en_i = lk; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // returns cycles the done pulse stayed high (0 if never seen)
  task automatic await_done(output int width, output logic [15:0] rem_at_done);
    width = 0; rem_at_done = 16'hFFFF;
    for (int k = 0; k < 5000; k++) begin
      if (done_o) begin
        rem_at_done = remain_o;
        while (done_o && width < 8) begin width++; @(negedge clk_i); end
        break;
      end
      @(negedge clk_i);
    end
  endtask

  localparam int NV = 8;
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h13F0, 32'h2000, 32'h4000,
                                          32'h4000, 32'h5100, 32'h6000, 32'h7FFC};
  localparam logic [15:0] V_LEN  [NV] = '{16'd64, 16'd64, 16'd1024, 16'd1024,
                                          16'd2048, 16'd1024, 16'd40, 16'd16};
  localparam logic [8:0]  V_EP   [NV] = '{9'd64, 9'd64, 9'd128, 9'd256,
                                          9'd256, 9'd256, 9'd8, 9'd0};
  localparam int          V_NB   [NV] = '{1, 2, 2, 1, 2, 2, 2, 2};
  localparam int          V_FB   [NV] = '{16, 4, 128, 256, 256, 192, 8, 1};
  localparam logic [31:0] V_SEC  [NV] = '{32'h0, 32'h1400, 32'h2200, 32'h0,
                                          32'h4400, 32'h5400, 32'h0, 32'h8000};
  localparam logic        V_LK   [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic        V_ST   [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  initial begin
    int w;
    logic [15:0] r;
    req_prev = 0; blk_cnt = 0; lock_cfg = 0; stall_en = 0; drop_en = 0; dropped = 0;
    ep_eff = 256; exp_addr = 0; bseen = 0; nb = 0; viol_lock = 0;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk(!bus_req_o && !bus_lock_o && !beat_valid_o && !busy_o && !done_o && !err_o,
        "R12 outputs in reset", {bus_req_o, bus_lock_o, busy_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(remain_o == 0 && !busy_o && !bus_req_o, "R12 after reset", remain_o, 0);

    for (int i = 0; i < NV; i++) begin
      launch(V_ADDR[i], V_LEN[i], V_EP[i], V_LK[i], V_ST[i], 1'b0);
      await_done(w, r);
      chk(w == 1, "R8 done width", w, 1);
      chk(r == 0, "R8 remain at done", r, 0);
      chk(nb == V_NB[i], "R5 burst count", nb, V_NB[i]);
      chk(first_beats == V_FB[i], "R5 R6 first burst beats", first_beats, V_FB[i]);
      if (V_SEC[i] != 0) chk(sec_addr == V_SEC[i], "R3 R6 second burst address", sec_addr, V_SEC[i]);
      chk(bseen == V_LEN[i] / 4, "R1 total beats", bseen, V_LEN[i] / 4);
      chk(viol_addr == 0, "R1 beat address sequence", viol_addr, 0);
      chk(viol_bound == 0, "R3 boundary crossing", viol_bound, 0);
      chk(viol_cap == 0, "R2 beat cap", viol_cap, 0);
      chk(viol_hold == 0, "R9 descriptor hold", viol_hold, 0);
      chk(viol_lock == 0, "R7 lock tracking", viol_lock, 0);
    end

    // R4 grant withdrawn after five beats
    launch(32'h8000, 16'd64, 9'd64, 1'b1, 1'b0, 1'b1);
    await_done(w, r);
    chk(nb == 2, "R4 reissue count", nb, 2);
    chk(sec_addr == 32'h8014, "R4 reissue address", sec_addr, 32'h8014);
    chk(sec_beats == 11, "R4 reissue beats", sec_beats, 11);
    chk(bseen == 16 && viol_addr == 0, "R4 all words moved", bseen, 16);
    chk(viol_lock == 0, "R7 lock through reissue", viol_lock, 0);
    chk(w == 1, "R8 done after reissue", w, 1);

    // R11 zero length
    launch(32'h9000, 16'd0, 9'd64, 1'b0, 1'b0, 1'b0);
    chk(done_o == 1'b1, "R11 immediate done", done_o, 1);
    repeat (4) @(negedge clk_i);
    chk(nb == 0 && !busy_o, "R11 no request", nb, 0);

    // R10 bad length
    launch(32'hA000, 16'd6, 9'd64, 1'b1, 1'b0, 1'b0);
    chk(err_o == 1'b1 && done_o == 1'b0, "R10 error pulse", err_o, 1);
    @(negedge clk_i);
    chk(err_o == 1'b0, "R10 error one cycle", err_o, 0);
    repeat (4) @(negedge clk_i);
    chk(nb == 0 && !busy_o && !bus_lock_o, "R10 no transfer", nb, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule